// File: doc/BRIEF.md
# Dual-Bank Integer Multiply-Accumulate Unit

This unit carries out 32-bit integer multiplies and multiply-accumulates for a processor's execute stage. It holds two accumulator banks. Each bank has a high word and a low word, and together they form one 64-bit value. An operation arrives as a one-cycle strobe that carries an operation code, two source operands, a destination register index and a bank select. A multiply sends the low result word back for write-back to the general register file. In the same cycle the selected bank receives the full 64-bit result. A multiply-add adds the product to the bank's concatenated 64-bit value before storing it.

Bank 1 can also be read into a general register or loaded from one, one word at a time. Any operation code outside the supported set produces a reserved-instruction pulse and changes nothing. Every result, write-enable and completion pulse is registered and appears on the cycle after the strobe. Both banks are also driven out continuously so that neighbouring logic can use them.

Top module: `dual_acc_mac`

## Requirements
- R1: After reset both banks read zero, and `done`, `wb_en` and `rsvd_err` are low.
- R2: Code 0 (signed multiply) forms the 64-bit product of `src_a` and `src_b` as signed 32-bit values. The selected bank's high word takes bits 63:32 and its low word takes bits 31:0. `wb_data` carries bits 31:0.
- R3: Code 1 (unsigned multiply) zero-extends both operands before multiplying. It stores and returns the result as in R2.
- R4: Code 2 (signed multiply-add) adds the signed product to the selected bank's {high,low} value. The sum wraps modulo 2^64 and is stored back into the bank. `wb_data` carries bits 31:0 of the sum.
- R5: Code 3 (unsigned multiply-add) works like R4, but with zero-extended operands.
- R6: Codes 0 to 3 change only the bank named by `bank_sel`. The other bank holds its value.
- R7: An arithmetic code with `dst_idx` equal to 0 still updates the bank, but `wb_en` stays low.
- R8: Code 4 returns the bank 1 high word on `wb_data` and code 5 returns the bank 1 low word. `wb_en` is high only when `dst_idx` is nonzero. Neither code changes any bank.
- R9: Code 6 loads the bank 1 high word and code 7 loads the bank 1 low word, taking the value from `src_a`. When `src_idx` is 0 the value loaded is zero, whatever `src_a` holds. Bank 0 and the other word of bank 1 are unchanged.
- R10: Codes 8 to 15 pulse `rsvd_err` with `done` and hold `wb_en` low. No bank changes.
- R11: `done` pulses for exactly one cycle, on the cycle after each accepted `op_valid`. With `op_valid` low, `done`, `wb_en`, `rsvd_err` and both banks stay unchanged or low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 4 | Operation code |
| bank_sel | input | 1 | Accumulator bank for codes 0 to 3 |
| src_a | input | 32 | First operand, or the value to load for codes 6 and 7 |
| src_b | input | 32 | Second operand |
| src_idx | input | 5 | Register index that `src_a` was read from |
| dst_idx | input | 5 | Destination register index |
| done | output | 1 | Completion pulse, one cycle after the strobe |
| wb_en | output | 1 | Register write-back enable |
| wb_idx | output | 5 | Register write-back index |
| wb_data | output | 32 | Register write-back data |
| rsvd_err | output | 1 | Reserved operation code pulse |
| acc_hi | output | 64 | High words: bank 0 in bits 31:0, bank 1 in bits 63:32 |
| acc_lo | output | 64 | Low words, packed the same way |

## Verification
The assertions take it that `op_valid` only ever carries a fully defined code, index set and operands. They also take it that no operation arrives while the internal reset is still held. The stimulus always drives the inputs on the falling edge and holds the strobe for exactly one cycle. After reset it waits for the internal release before issuing any operation. Each operation is followed by an idle cycle, so every consequent is judged against a single preceding operation.

// File: rtl/dam_pkg.sv
package dam_pkg;

  typedef enum logic [3:0] {
    OP_MULS = 4'd0,
    OP_MULU = 4'd1,
    OP_MACS = 4'd2,
    OP_MACU = 4'd3,
    OP_RDHI = 4'd4,
    OP_RDLO = 4'd5,
    OP_WRHI = 4'd6,
    OP_WRLO = 4'd7
  } dam_op_e;

  typedef struct packed {
    logic arith;
    logic sgn;
    logic accum;
    logic rd_hi;
    logic rd_lo;
    logic wr_hi;
    logic wr_lo;
    logic rsvd;
  } dam_ctrl_t;

endpackage

// File: rtl/dam_decode.sv
module dam_decode
  import dam_pkg::*;
(
  input  logic [3:0] op_code,
  output dam_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (op_code)
      OP_MULS: begin ctrl.arith = 1'b1; ctrl.sgn = 1'b1; end
      OP_MULU: begin ctrl.arith = 1'b1; end
      OP_MACS: begin ctrl.arith = 1'b1; ctrl.sgn = 1'b1; ctrl.accum = 1'b1; end
      OP_MACU: begin ctrl.arith = 1'b1; ctrl.accum = 1'b1; end
      OP_RDHI: ctrl.rd_hi = 1'b1;
      OP_RDLO: ctrl.rd_lo = 1'b1;
      OP_WRHI: ctrl.wr_hi = 1'b1;
      OP_WRLO: ctrl.wr_lo = 1'b1;
      default: ctrl.rsvd = 1'b1;
    endcase
  end

endmodule

// File: rtl/dam_mul_add.sv
module dam_mul_add #(
  parameter int W = 32
) (
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  input  logic           sgn,
  input  logic           accum,
  input  logic [2*W-1:0] acc_in,
  output logic [2*W-1:0] result
);

  localparam int PW = 2 * W;

  logic [PW-1:0] ext_a;
  logic [PW-1:0] ext_b;
  logic [PW-1:0] product;
  logic [PW-1:0] addend;

  // Extension to the full product width; the low PW bits of the product of
  // the extended values equal the exact signed or unsigned product.
  always_comb begin
    ext_a   = {{W{sgn & opa[W-1]}}, opa};
    ext_b   = {{W{sgn & opb[W-1]}}, opb};
    product = ext_a * ext_b;
    addend  = accum ? acc_in : '0;
    result  = product + addend;
  end

endmodule

// File: rtl/dam_acc_bank.sv
module dam_acc_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_hi,
  input  logic         en_lo,
  input  logic [W-1:0] hi_d,
  input  logic [W-1:0] lo_d,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (en_hi) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (en_lo) begin
      lo_q <= lo_d;
    end
  end

endmodule

// File: rtl/dual_acc_mac.sv
module dual_acc_mac
  import dam_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int NUM_BANKS = 2,
  parameter int MOVE_BANK = 1,
  parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [3:0]                  op_code,
  input  logic [BANK_W-1:0]           bank_sel,
  input  logic [DATA_W-1:0]           src_a,
  input  logic [DATA_W-1:0]           src_b,
  input  logic [IDX_W-1:0]            src_idx,
  input  logic [IDX_W-1:0]            dst_idx,
  output logic                        done,
  output logic                        wb_en,
  output logic [IDX_W-1:0]            wb_idx,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        rsvd_err,
  output logic [NUM_BANKS*DATA_W-1:0] acc_hi,
  output logic [NUM_BANKS*DATA_W-1:0] acc_lo
);

  localparam int PW = 2 * DATA_W;

  // Reset: asserted at once, released through two flops
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  dam_ctrl_t ctrl;
  dam_decode u_dec (.op_code(op_code), .ctrl(ctrl));

  logic [DATA_W-1:0] hi_q [NUM_BANKS];
  logic [DATA_W-1:0] lo_q [NUM_BANKS];
  logic [PW-1:0]     sel_acc;
  logic [PW-1:0]     mac_out;
  logic [DATA_W-1:0] move_val;

  always_comb begin
    sel_acc = '0;
    for (int k = 0; k < NUM_BANKS; k++) begin
      if (bank_sel == BANK_W'(k)) sel_acc = {hi_q[k], lo_q[k]};
    end
    move_val = (src_idx == '0) ? '0 : src_a;
  end

  dam_mul_add #(.W(DATA_W)) u_mac (
    .opa(src_a), .opb(src_b), .sgn(ctrl.sgn), .accum(ctrl.accum),
    .acc_in(sel_acc), .result(mac_out)
  );

  // Per-bank write enables and data
  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic              en_hi, en_lo;
    logic [DATA_W-1:0] hi_d, lo_d;
    logic              hit;
    always_comb begin
      hit   = op_valid && ctrl.arith && (bank_sel == BANK_W'(g));
      en_hi = hit || (op_valid && ctrl.wr_hi && (g == MOVE_BANK));
      en_lo = hit || (op_valid && ctrl.wr_lo && (g == MOVE_BANK));
      hi_d  = ctrl.arith ? mac_out[PW-1:DATA_W] : move_val;
      lo_d  = ctrl.arith ? mac_out[DATA_W-1:0]  : move_val;
    end
    dam_acc_bank #(.W(DATA_W)) u_bank (
      .clk(clk), .rst_n(rst_sync_n), .en_hi(en_hi), .en_lo(en_lo),
      .hi_d(hi_d), .lo_d(lo_d), .hi_q(hi_q[g]), .lo_q(lo_q[g])
    );
    assign acc_hi[g*DATA_W +: DATA_W] = hi_q[g];
    assign acc_lo[g*DATA_W +: DATA_W] = lo_q[g];
  end

  // Write-back next state
  logic              done_d, wb_en_d, rsvd_d;
  logic [DATA_W-1:0] wb_data_d;
  always_comb begin
    done_d  = op_valid;
    rsvd_d  = op_valid && ctrl.rsvd;
    wb_en_d = op_valid && (ctrl.arith || ctrl.rd_hi || ctrl.rd_lo)
              && (dst_idx != '0);
    if (ctrl.arith)      wb_data_d = mac_out[DATA_W-1:0];
    else if (ctrl.rd_hi) wb_data_d = hi_q[MOVE_BANK];
    else                 wb_data_d = lo_q[MOVE_BANK];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done     <= 1'b0;
      wb_en    <= 1'b0;
      rsvd_err <= 1'b0;
    end else begin
      done     <= done_d;
      wb_en    <= wb_en_d;
      rsvd_err <= rsvd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wb_idx  <= '0;
      wb_data <= '0;
    end else if (op_valid) begin
      wb_idx  <= dst_idx;
      wb_data <= wb_data_d;
    end
  end

endmodule

// File: rtl/dam_checker.sv
module dam_checker #(
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 5,
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        op_valid,
  input logic [3:0]                  op_code,
  input logic [BANK_W-1:0]           bank_sel,
  input logic [DATA_W-1:0]           src_a,
  input logic [DATA_W-1:0]           src_b,
  input logic [IDX_W-1:0]            dst_idx,
  input logic                        done,
  input logic                        wb_en,
  input logic [IDX_W-1:0]            wb_idx,
  input logic                        rsvd_err,
  input logic [NUM_BANKS*DATA_W-1:0] acc_hi,
  input logic [NUM_BANKS*DATA_W-1:0] acc_lo
);

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> done); // R11

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!done && !wb_en && !rsvd_err && $stable(acc_hi) && $stable(acc_lo))); // R11

  AST_NO_WB_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != '0)); // R7

  AST_RSVD_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code[3]) |=> (rsvd_err && !wb_en && $stable(acc_hi) && $stable(acc_lo))); // R10

  AST_READ_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd4 || op_code == 4'd5)) |=> ($stable(acc_hi) && $stable(acc_lo))); // R8

  AST_LOAD_SPARES_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 4'd6 || op_code == 4'd7))
    |=> ($stable(acc_hi[DATA_W-1:0]) && $stable(acc_lo[DATA_W-1:0]))); // R9

  AST_BANK1_ARITH_SPARES_BANK0: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code < 4'd4 && bank_sel == 1'b1)
    |=> ($stable(acc_hi[DATA_W-1:0]) && $stable(acc_lo[DATA_W-1:0]))); // R6

  AST_UMUL_BANK0_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd1 && bank_sel == 1'b0)
    |=> ({acc_hi[DATA_W-1:0], acc_lo[DATA_W-1:0]} ==
         {{DATA_W{1'b0}}, $past(src_a)} * {{DATA_W{1'b0}}, $past(src_b)})); // R3

  AST_WB_IDX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (wb_idx == $past(dst_idx))); // R11

endmodule

bind dual_acc_mac dam_checker #(
  .DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .op_valid(op_valid), .op_code(op_code),
  .bank_sel(bank_sel), .src_a(src_a), .src_b(src_b), .dst_idx(dst_idx),
  .done(done), .wb_en(wb_en), .wb_idx(wb_idx), .rsvd_err(rsvd_err),
  .acc_hi(acc_hi), .acc_lo(acc_lo)
);

// File: tb/sim_dual_acc_mac.sv
`timescale 1ns/1ps
module sim_dual_acc_mac;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic        bank_sel;
  logic [31:0] src_a, src_b;
  logic [4:0]  src_idx, dst_idx;
  logic        done, wb_en, rsvd_err;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data;
  logic [63:0] acc_hi, acc_lo;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic [63:0] m_acc [2];   // model {hi,lo} per bank

  always #2.5 clk = ~clk;

  dual_acc_mac u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .bank_sel(bank_sel), .src_a(src_a), .src_b(src_b), .src_idx(src_idx),
    .dst_idx(dst_idx), .done(done), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .rsvd_err(rsvd_err), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [63:0] prod(input logic [31:0] a, input logic [31:0] b, input bit s);
    logic [63:0] xa, xb;
    xa = s ? {{32{a[31]}}, a} : {32'd0, a};
    xb = s ? {{32{b[31]}}, b} : {32'd0, b};
    return xa * xb;
  endfunction

  // Drive one operation for one cycle; return after the result edge
  task automatic issue(input logic [3:0] op, input logic bk, input logic [31:0] a,
                       input logic [31:0] b, input logic [4:0] si, input logic [4:0] di);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; bank_sel = bk;
    src_a = a; src_b = b; src_idx = si; dst_idx = di;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic check_banks(input string req);
    chk(req, {acc_hi[31:0], acc_lo[31:0]}, m_acc[0]);
    chk(req, {acc_hi[63:32], acc_lo[63:32]}, m_acc[1]);
  endtask

  task automatic check_wb(input string req, input bit en, input logic [31:0] d);
    chk(req, {63'd0, done}, 64'd1);
    chk(req, {63'd0, wb_en}, {63'd0, en});
    if (en) begin
      chk(req, {59'd0, wb_idx}, {59'd0, dst_idx});
      chk(req, {32'd0, wb_data}, {32'd0, d});
    end
    chk(req, {63'd0, rsvd_err}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1", acc_hi, 64'd0);
    chk("R1", acc_lo, 64'd0);
    chk("R1", {61'd0, done, wb_en, rsvd_err}, 64'd0);
  endtask

  task automatic arith(input string req, input logic [3:0] op, input logic bk,
                       input logic [31:0] a, input logic [31:0] b, input logic [4:0] di);
    logic [63:0] r;
    r = prod(a, b, (op == 4'd0) || (op == 4'd2));
    if (op >= 4'd2) r = r + m_acc[bk];
    m_acc[bk] = r;
    issue(op, bk, a, b, 5'd3, di);
    check_wb(req, di != 0, r[31:0]);
    check_banks(req);
  endtask

  task automatic t_mul_signed;
    arith("R2", 4'd0, 1'b0, 32'hFFFF_FFFD, 32'd7, 5'd4);
    arith("R2", 4'd0, 1'b0, 32'h8000_0000, 32'h8000_0000, 5'd9);
    arith("R2", 4'd0, 1'b0, 32'h1234_5678, 32'hFEDC_BA98, 5'd31);
  endtask

  task automatic t_mul_unsigned;
    arith("R3", 4'd1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd2);
    arith("R3", 4'd1, 1'b1, 32'h8000_0001, 32'd3, 5'd5);
  endtask

  task automatic t_mac_signed;
    arith("R4", 4'd2, 1'b0, 32'hFFFF_FFFF, 32'd5, 5'd6);
    arith("R4", 4'd2, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 5'd6);
    // wrap of the 64-bit sum
    m_acc[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    issue(4'd6, 1'b0, 32'hFFFF_FFFF, 32'd0, 5'd1, 5'd0);
    issue(4'd7, 1'b0, 32'hFFFF_FFFF, 32'd0, 5'd1, 5'd0);
    arith("R4", 4'd2, 1'b1, 32'd2, 32'd1, 5'd7);
  endtask

  task automatic t_mac_unsigned;
    arith("R5", 4'd3, 1'b1, 32'hFFFF_FFFF, 32'h0000_0010, 5'd8);
    arith("R5", 4'd3, 1'b1, 32'h8000_0000, 32'd2, 5'd8);
  endtask

  task automatic t_bank_iso;
    arith("R6", 4'd0, 1'b1, 32'd11, 32'd13, 5'd10);
    arith("R6", 4'd1, 1'b0, 32'd17, 32'd19, 5'd10);
  endtask

  task automatic t_dst_zero;
    arith("R7", 4'd3, 1'b0, 32'd100, 32'd100, 5'd0);
    arith("R7", 4'd0, 1'b1, 32'hFFFF_FFF0, 32'd2, 5'd0);
  endtask

  task automatic t_move_from;
    issue(4'd4, 1'b0, 32'hDEAD_BEEF, 32'd0, 5'd1, 5'd12);
    check_wb("R8", 1'b1, m_acc[1][63:32]);
    check_banks("R8");
    issue(4'd5, 1'b0, 32'hDEAD_BEEF, 32'd0, 5'd1, 5'd13);
    check_wb("R8", 1'b1, m_acc[1][31:0]);
    issue(4'd5, 1'b1, 32'd0, 32'd0, 5'd1, 5'd0);
    check_wb("R8", 1'b0, 32'd0);
    check_banks("R8");
  endtask

  task automatic t_move_to;
    issue(4'd6, 1'b0, 32'hCAFE_0001, 32'd0, 5'd7, 5'd0);
    m_acc[1][63:32] = 32'hCAFE_0001;
    check_wb("R9", 1'b0, 32'd0);
    check_banks("R9");
    issue(4'd7, 1'b0, 32'hCAFE_0002, 32'd0, 5'd8, 5'd0);
    m_acc[1][31:0] = 32'hCAFE_0002;
    check_banks("R9");
    issue(4'd6, 1'b0, 32'h5555_AAAA, 32'd0, 5'd0, 5'd0);
    m_acc[1][63:32] = 32'd0;
    check_banks("R9");
    issue(4'd7, 1'b0, 32'h5555_AAAA, 32'd0, 5'd0, 5'd0);
    m_acc[1][31:0] = 32'd0;
    check_banks("R9");
  endtask

  task automatic t_reserved;
    for (int c = 8; c < 16; c++) begin
      issue(4'(c), c[0], 32'h1111_2222, 32'h3333_4444, 5'd1, 5'd9);
      chk("R10", {62'd0, done, rsvd_err}, 64'd3);
      chk("R10", {63'd0, wb_en}, 64'd0);
      check_banks("R10");
    end
  endtask

  task automatic t_idle;
    @(negedge clk);
    op_code = 4'd3; src_a = 32'hFFFF_FFFF; src_b = 32'hFFFF_FFFF; dst_idx = 5'd4;
    @(negedge clk);
    @(negedge clk);
    chk("R11", {61'd0, done, wb_en, rsvd_err}, 64'd0);
    check_banks("R11");
    issue(4'd1, 1'b0, 32'd1, 32'd1, 5'd1, 5'd2);
    m_acc[0] = 64'd1;
    @(negedge clk);
    chk("R11", {63'd0, done}, 64'd0);
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    m_acc[0] = '0; m_acc[1] = '0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; bank_sel = 1'b0;
    src_a = '0; src_b = '0; src_idx = '0; dst_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_mul_signed();
    t_mul_unsigned();
    t_mac_signed();
    t_mac_unsigned();
    t_bank_iso();
    t_dst_zero();
    t_move_from();
    t_move_to();
    t_reserved();
    t_idle();
    report();
  end

endmodule